// File: doc/BRIEF.md
# Configurable Synchronous Serial Port

This block is a full-duplex synchronous serial port. A receive channel shifts words in on a data-in pin and a transmit channel shifts words out on a data-out pin. Each channel has its own bit clock and its own load (frame) strobe. A control register sets each of these four timing signals separately: the port either takes it from an external device (passive) or drives it itself (active). The same register sets the word length of each direction (8 or 16 bits), one bit order shared by both directions, and whether data-out changes on the rising or the falling edge of the transmit clock.

On the parallel side there is a write data register with an empty flag and a read data register with a full flag. External clocks and strobes pass through two-flop synchronizers, and all edge detection runs in the system clock domain. In active mode the port makes its bit clock by dividing the system clock. It makes its load strobe by counting bit-clock periods, so the strobe is high for one bit period out of every `FRAME_BITS`.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the control register is zero. Every `*_oe` output is 0, `tx_empty` is 1, `rx_full` is 0 and `sdo` is 0.
- R2: Control bits 3, 4, 5 and 6 make the receive clock, transmit clock, receive strobe and transmit strobe active, in that order. Each one drives its own `*_oe` pin to 1, and a 0 leaves that pin passive.
- R3: Control bit 0 selects the receive length: 0 means 16 bits and 1 means 8 bits. When the last bit arrives, the word goes to `rx_rdata` and `rx_full` is set. An 8-bit word is right-justified and zero-extended. Asserting `rx_re` clears `rx_full`.
- R4: Control bit 2 sets the bit order for both directions: 0 sends and receives LSB first, 1 sends and receives MSB first.
- R5: A receive word starts only on a rising receive clock edge at which the receive strobe is high. Rising edges after the last bit, with no strobe, produce no word.
- R6: A write to the transmit register clears `tx_empty`. The word is loaded at the next transmit-clock update edge at which the transmit strobe is high. `tx_empty` is set again at the update edge after the last bit. If no strobe comes, the word is not sent. Control bit 1 selects the transmit length: 0 means 16 bits and 1 means 8 bits.
- R7: Control bit 7 at 0 makes `sdo` change on the rising transmit-clock edge. At 1, `sdo` changes on the falling edge instead.
- R8: While no word is being shifted out, `sdo` holds the last bit that was driven.
- R9: An active bit clock toggles every `HALF_DIV` system clock cycles.
- R10: An active load strobe is high for exactly one bit-clock period in every `FRAME_BITS` periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | CFG_W (8) | Control register write data |
| tx_we | input | 1 | Transmit register write enable |
| tx_wdata | input | DATA_W | Transmit word |
| rx_re | input | 1 | Read acknowledge, clears `rx_full` |
| rx_rdata | output | DATA_W | Last received word |
| rx_full | output | 1 | Receive register holds an unread word |
| tx_empty | output | 1 | Nothing pending or shifting for transmit |
| in_clk_i | input | 1 | Receive bit clock from an external device |
| in_clk_o | output | 1 | Receive bit clock driven by the port |
| in_clk_oe | output | 1 | Receive clock pin is driven |
| in_ld_i | input | 1 | Receive strobe from an external device |
| in_ld_o | output | 1 | Receive strobe driven by the port |
| in_ld_oe | output | 1 | Receive strobe pin is driven |
| sdi | input | 1 | Serial data in |
| out_clk_i | input | 1 | Transmit bit clock from an external device |
| out_clk_o | output | 1 | Transmit bit clock driven by the port |
| out_clk_oe | output | 1 | Transmit clock pin is driven |
| out_ld_i | input | 1 | Transmit strobe from an external device |
| out_ld_o | output | 1 | Transmit strobe driven by the port |
| out_ld_oe | output | 1 | Transmit strobe pin is driven |
| sdo | output | 1 | Serial data out |

## Verification
A pin edge takes three system clock cycles to act: two synchronizer flops and one edge-detect register. So `sdo` settles three cycles after the clock pin moves, and `rx_full` rises three cycles after the last receive rising edge. The bench holds each bit-clock phase for eight cycles and samples `sdo` only at the end of a phase, long after it has settled. It samples before the falling edge in rising-edge mode and before the next rising edge in falling-edge mode. A scoreboard monitor accepts a received word whenever `rx_full` is seen, so it does not depend on the exact cycle. Active-clock measurements start only after several full frames, then count edges over a window that is a whole number of frames long.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int CFG_W = 8;

  // Control register layout, bit 7 down to bit 0
  typedef struct packed {
    logic sdo_late;    // 7: data-out updates on falling edge
    logic tx_ld_act;   // 6
    logic rx_ld_act;   // 5
    logic tx_clk_act;  // 4
    logic rx_clk_act;  // 3
    logic msb_first;   // 2
    logic tx_short;    // 1: 8-bit transmit
    logic rx_short;    // 0: 8-bit receive
  } ssp_cfg_t;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= {q[STAGES-2:0], din};
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int HALF_DIV   = 4,
  parameter int FRAME_BITS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic chan_fall,
  output logic gen_clk,
  output logic strobe
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int FR_W  = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;

  logic [DIV_W-1:0] div_cnt;
  logic [FR_W-1:0]  frame_cnt;

  // free-running divider for the active bit clock
  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      gen_clk <= 1'b0;
    end else if (div_cnt == DIV_W'(HALF_DIV - 1)) begin
      div_cnt <= '0;
      gen_clk <= ~gen_clk;
    end else begin
      div_cnt <= div_cnt + DIV_W'(1);
    end
  end

  // strobe spans one bit period, from one falling edge to the next
  always_ff @(posedge clk) begin
    if (rst) begin
      frame_cnt <= '0;
      strobe    <= 1'b0;
    end else if (chan_fall) begin
      if (frame_cnt == FR_W'(FRAME_BITS - 1)) begin
        frame_cnt <= '0;
        strobe    <= 1'b1;
      end else begin
        frame_cnt <= frame_cnt + FR_W'(1);
        strobe    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_rise,
  input  logic              ld_level,
  input  logic              sdi,
  input  logic              short_mode,
  input  logic              msb_first,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic              full
);
  localparam int HALF_W = DATA_W / 2;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  logic [1:0]        sdi_q;
  logic [DATA_W-1:0] sr, cur, nxt, word;
  logic [CNT_W-1:0]  cnt, cnt_n, len;
  logic              busy, start, last, b;

  always_comb begin
    b     = sdi_q[1];
    start = bit_rise & ld_level;
    cur   = start ? '0 : sr;
    nxt   = msb_first ? {cur[DATA_W-2:0], b} : {b, cur[DATA_W-1:1]};
    len   = short_mode ? CNT_W'(HALF_W) : CNT_W'(DATA_W);
    cnt_n = start ? CNT_W'(1) : cnt + CNT_W'(1);
    last  = (cnt_n == len);
    if (!short_mode)    word = nxt;
    else if (msb_first) word = nxt & {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    else                word = nxt >> HALF_W;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdi_q <= '0;
      sr    <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      rdata <= '0;
      full  <= 1'b0;
    end else begin
      sdi_q <= {sdi_q[0], sdi};
      if (rd_en) full <= 1'b0;
      if (bit_rise && (start || busy)) begin
        sr  <= nxt;
        cnt <= cnt_n;
        if (last) begin
          busy  <= 1'b0;
          rdata <= word;
          full  <= 1'b1;
        end else begin
          busy <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_edge,
  input  logic              ld_level,
  input  logic              short_mode,
  input  logic              msb_first,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              sdo,
  output logic              empty
);
  localparam int HALF_W = DATA_W / 2;
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int IDX_W  = $clog2(DATA_W);

  logic [DATA_W-1:0] hold, sr;
  logic [CNT_W-1:0]  idx, len;
  logic [IDX_W-1:0]  pos_run, pos_first;
  logic              pending, busy, run_bit, first_bit;

  always_comb begin
    len       = short_mode ? CNT_W'(HALF_W) : CNT_W'(DATA_W);
    pos_run   = msb_first ? IDX_W'(len - idx - CNT_W'(1)) : IDX_W'(idx);
    pos_first = msb_first ? IDX_W'(len - CNT_W'(1)) : '0;
    run_bit   = sr[pos_run];
    first_bit = hold[pos_first];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold    <= '0;
      sr      <= '0;
      idx     <= '0;
      pending <= 1'b0;
      busy    <= 1'b0;
      sdo     <= 1'b0;
      empty   <= 1'b1;
    end else begin
      if (upd_edge) begin
        if (busy) begin
          if (idx == len) begin
            busy  <= 1'b0;
            empty <= ~pending;
          end else begin
            sdo <= run_bit;
            idx <= idx + CNT_W'(1);
          end
        end else if (ld_level && pending) begin
          sr      <= hold;
          pending <= 1'b0;
          busy    <= 1'b1;
          sdo     <= first_bit;
          idx     <= CNT_W'(1);
        end
      end
      if (wr_en) begin
        hold    <= wdata;
        pending <= 1'b1;
        empty   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DATA_W      = 16,
  parameter int HALF_DIV    = 4,
  parameter int FRAME_BITS  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [ssp_pkg::CFG_W-1:0]  cfg_wdata,
  input  logic                       tx_we,
  input  logic [DATA_W-1:0]          tx_wdata,
  input  logic                       rx_re,
  output logic [DATA_W-1:0]          rx_rdata,
  output logic                       rx_full,
  output logic                       tx_empty,
  input  logic                       in_clk_i,
  output logic                       in_clk_o,
  output logic                       in_clk_oe,
  input  logic                       in_ld_i,
  output logic                       in_ld_o,
  output logic                       in_ld_oe,
  input  logic                       sdi,
  input  logic                       out_clk_i,
  output logic                       out_clk_o,
  output logic                       out_clk_oe,
  input  logic                       out_ld_i,
  output logic                       out_ld_o,
  output logic                       out_ld_oe,
  output logic                       sdo
);
  import ssp_pkg::*;

  localparam int NUM_SYNC = 4;  // rx clk, tx clk, rx strobe, tx strobe

  ssp_cfg_t            cfg;
  logic                rx_gen_clk, tx_gen_clk, rx_strobe, tx_strobe;
  logic [NUM_SYNC-1:0] raw, lvl;
  logic [1:0]          clk_prev, clk_rise, clk_fall;
  logic                rx_ld_level, tx_ld_level, tx_upd;

  always_ff @(posedge clk) begin
    if (rst)         cfg <= '0;
    else if (cfg_we) cfg <= ssp_cfg_t'(cfg_wdata);
  end

  // an active clock loops back through the same synchronizer as a passive one
  assign raw[0] = cfg.rx_clk_act ? rx_gen_clk : in_clk_i;
  assign raw[1] = cfg.tx_clk_act ? tx_gen_clk : out_clk_i;
  assign raw[2] = in_ld_i;
  assign raw[3] = out_ld_i;

  for (genvar i = 0; i < NUM_SYNC; i++) begin : g_sync
    ssp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (raw[i]),
      .dout(lvl[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) clk_prev <= '0;
    else     clk_prev <= lvl[1:0];
  end

  assign clk_rise = lvl[1:0] & ~clk_prev;
  assign clk_fall = ~lvl[1:0] & clk_prev;

  ssp_clkgen #(.HALF_DIV(HALF_DIV), .FRAME_BITS(FRAME_BITS)) u_rx_gen (
    .clk      (clk),
    .rst      (rst),
    .chan_fall(clk_fall[0]),
    .gen_clk  (rx_gen_clk),
    .strobe   (rx_strobe)
  );

  ssp_clkgen #(.HALF_DIV(HALF_DIV), .FRAME_BITS(FRAME_BITS)) u_tx_gen (
    .clk      (clk),
    .rst      (rst),
    .chan_fall(clk_fall[1]),
    .gen_clk  (tx_gen_clk),
    .strobe   (tx_strobe)
  );

  assign rx_ld_level = cfg.rx_ld_act ? rx_strobe : lvl[2];
  assign tx_ld_level = cfg.tx_ld_act ? tx_strobe : lvl[3];
  assign tx_upd      = cfg.sdo_late ? clk_fall[1] : clk_rise[1];

  ssp_rx #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .bit_rise  (clk_rise[0]),
    .ld_level  (rx_ld_level),
    .sdi       (sdi),
    .short_mode(cfg.rx_short),
    .msb_first (cfg.msb_first),
    .rd_en     (rx_re),
    .rdata     (rx_rdata),
    .full      (rx_full)
  );

  ssp_tx #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .upd_edge  (tx_upd),
    .ld_level  (tx_ld_level),
    .short_mode(cfg.tx_short),
    .msb_first (cfg.msb_first),
    .wr_en     (tx_we),
    .wdata     (tx_wdata),
    .sdo       (sdo),
    .empty     (tx_empty)
  );

  assign in_clk_o   = rx_gen_clk;
  assign out_clk_o  = tx_gen_clk;
  assign in_ld_o    = rx_strobe;
  assign out_ld_o   = tx_strobe;
  assign in_clk_oe  = cfg.rx_clk_act;
  assign out_clk_oe = cfg.tx_clk_act;
  assign in_ld_oe   = cfg.rx_ld_act;
  assign out_ld_oe  = cfg.tx_ld_act;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
  parameter int HALF_DIV = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       cfg_we,
  input logic [7:0] cfg_wdata,
  input logic       tx_we,
  input logic       rx_re,
  input logic       rx_full,
  input logic       tx_empty,
  input logic       sdo,
  input logic       out_clk_o,
  input logic       in_clk_oe,
  input logic       out_clk_oe,
  input logic       in_ld_oe,
  input logic       out_ld_oe
);
  int   hold_cnt;
  logic clk_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= 0;
      clk_seen <= 1'b0;
    end else begin
      clk_seen <= out_clk_o;
      if (out_clk_o != clk_seen) hold_cnt <= 0;
      else                       hold_cnt <= hold_cnt + 1;
    end
  end

  AST_OE_TRACKS_CFG: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (in_clk_oe == $past(cfg_wdata[3]) && out_clk_oe == $past(cfg_wdata[4]) &&
                in_ld_oe == $past(cfg_wdata[5]) && out_ld_oe == $past(cfg_wdata[6]))); // R2

  AST_OE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable({in_clk_oe, out_clk_oe, in_ld_oe, out_ld_oe})); // R2

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !rx_re) |=> rx_full); // R3

  AST_EMPTY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    tx_we |=> !tx_empty); // R6

  AST_SDO_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_empty && $past(tx_empty)) |-> $stable(sdo)); // R8

  AST_CLK_HALF_PERIOD: assert property (@(posedge clk) disable iff (rst)
    hold_cnt <= HALF_DIV); // R9
endmodule

bind sync_serial_port ssp_checker #(.HALF_DIV(HALF_DIV)) u_ssp_checker (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .tx_we     (tx_we),
  .rx_re     (rx_re),
  .rx_full   (rx_full),
  .tx_empty  (tx_empty),
  .sdo       (sdo),
  .out_clk_o (out_clk_o),
  .in_clk_oe (in_clk_oe),
  .out_clk_oe(out_clk_oe),
  .in_ld_oe  (in_ld_oe),
  .out_ld_oe (out_ld_oe)
);

// File: tb/sync_serial_port_test.sv
module sync_serial_port_test;
  localparam int DUT_HD = 4;
  localparam int DUT_FR = 16;
  localparam int HALF   = 8;
  localparam int NCLK   = 18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic        tx_we = 1'b0;
  logic [15:0] tx_wdata = '0;
  logic        rx_re = 1'b0;
  logic [15:0] rx_rdata;
  logic        rx_full, tx_empty;
  logic        bclk = 1'b0, ld = 1'b0, sdi = 1'b0;
  logic        in_clk_o, in_clk_oe, in_ld_o, in_ld_oe;
  logic        out_clk_o, out_clk_oe, out_ld_o, out_ld_oe, sdo;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] rx_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  sync_serial_port #(.DATA_W(16), .HALF_DIV(DUT_HD), .FRAME_BITS(DUT_FR)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tx_we(tx_we), .tx_wdata(tx_wdata), .rx_re(rx_re), .rx_rdata(rx_rdata),
    .rx_full(rx_full), .tx_empty(tx_empty),
    .in_clk_i(bclk), .in_clk_o(in_clk_o), .in_clk_oe(in_clk_oe),
    .in_ld_i(ld), .in_ld_o(in_ld_o), .in_ld_oe(in_ld_oe), .sdi(sdi),
    .out_clk_i(bclk), .out_clk_o(out_clk_o), .out_clk_oe(out_clk_oe),
    .out_ld_i(ld), .out_ld_o(out_ld_o), .out_ld_oe(out_ld_oe), .sdo(sdo)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mask(input int n);
    return (n >= 16) ? 16'hFFFF : 16'((1 << n) - 1);
  endfunction

  // scoreboard monitor: pops one expected word per rx_full
  always @(negedge clk) begin
    if (rst) rx_re = 1'b0;
    else if (rx_re) rx_re = 1'b0;
    else if (rx_full) begin
      if (rx_q.size() == 0) begin
        check(1'b0, "R5 unexpected receive word", rx_rdata, 0);
      end else begin
        logic [15:0] e;
        string t;
        e = rx_q.pop_front();
        t = tag_q.pop_front();
        check(rx_rdata == e, t, rx_rdata, e);
      end
      rx_re = 1'b1;
    end
  end

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic tx_write(input logic [15:0] w);
    @(negedge clk); tx_we = 1'b1; tx_wdata = w;
    @(negedge clk); tx_we = 1'b0;
    check(tx_empty == 1'b0, "R6 write clears empty", tx_empty, 0);
  endtask

  // driver: one frame of NCLK bit clocks on both channels
  task automatic run_frame(input logic [15:0] rxw, input int rx_len, input bit with_ld,
                           input logic [15:0] txw, input int tx_len,
                           input bit msb, input bit late, input string tag);
    logic [15:0] cap = '0;
    logic [15:0] got = '0;
    logic        hi_sample = 1'b0;
    if (with_ld) begin
      rx_q.push_back(rxw & mask(rx_len));
      tag_q.push_back({tag, " receive word"});
    end
    for (int k = 0; k < NCLK; k++) begin
      @(negedge clk);
      ld  = with_ld && (k == 0);
      sdi = (k < rx_len) ? (msb ? rxw[rx_len-1-k] : rxw[k]) : 1'b1;
      repeat (HALF) @(negedge clk);
      if (late && k >= 1 && (k - 1) < tx_len) cap[k-1] = sdo;
      bclk = 1'b1;
      repeat (HALF) @(negedge clk);
      if (!late && k < tx_len) cap[k] = sdo;
      if (late && k == 1) hi_sample = sdo;
      bclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    if (tx_len > 0) begin
      logic lastb, firstb;
      for (int k = 0; k < tx_len; k++) begin
        if (msb) got[tx_len-1-k] = cap[k];
        else     got[k] = cap[k];
      end
      check(got == (txw & mask(tx_len)), {tag, " transmit word"}, got, txw & mask(tx_len));
      check(tx_empty == 1'b1, "R6 empty after last bit", tx_empty, 1);
      lastb  = msb ? txw[0] : txw[tx_len-1];
      firstb = msb ? txw[tx_len-1] : txw[0];
      check(sdo == lastb, "R8 sdo holds last bit", sdo, lastb);
      if (late) check(hi_sample == firstb, "R7 no update on rising edge", hi_sample, firstb);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({in_clk_oe, out_clk_oe, in_ld_oe, out_ld_oe} == 4'b0, "R1 oe", {in_clk_oe, out_clk_oe, in_ld_oe, out_ld_oe}, 0);
    check(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
    check(rx_full == 1'b0, "R1 rx_full", rx_full, 0);
    check(sdo == 1'b0, "R1 sdo", sdo, 0);

    // 16-bit, LSB first, rising edge
    tx_write(16'h1234);
    run_frame(16'hA5C3, 16, 1'b1, 16'h1234, 16, 1'b0, 1'b0, "R3 lsb16");
    // MSB first, both directions (R4)
    cfg_write(8'h04);
    tx_write(16'hBEEF);
    run_frame(16'h8E71, 16, 1'b1, 16'hBEEF, 16, 1'b1, 1'b0, "R4 msb16");
    // 8-bit both, LSB first (R3, R6 length)
    cfg_write(8'h03);
    tx_write(16'h7755);
    run_frame(16'hFFD2, 8, 1'b1, 16'h7755, 8, 1'b0, 1'b0, "R3 R6 lsb8");
    // 8-bit both, MSB first
    cfg_write(8'h07);
    tx_write(16'h00C6);
    run_frame(16'h003B, 8, 1'b1, 16'h00C6, 8, 1'b1, 1'b0, "R4 msb8");
    // falling-edge update, 16-bit tx LSB, 8-bit rx (R7)
    cfg_write(8'h81);
    tx_write(16'h9A3E);
    run_frame(16'h0096, 8, 1'b1, 16'h9A3E, 16, 1'b0, 1'b1, "R7 late lsb");
    // falling-edge update, 8-bit tx MSB
    cfg_write(8'h86);
    tx_write(16'h00A5);
    run_frame(16'h4C1D, 16, 1'b1, 16'h00A5, 8, 1'b1, 1'b1, "R7 late msb");

    // no strobe: nothing loaded, nothing received (R5, R6, R8)
    cfg_write(8'h00);
    tx_write(16'h4242);
    begin
      logic s0;
      s0 = sdo;
      run_frame(16'hFFFF, 16, 1'b0, 16'h0000, 0, 1'b0, 1'b0, "R5 no strobe");
      check(tx_empty == 1'b0, "R6 no load without strobe", tx_empty, 0);
      check(sdo == s0, "R8 sdo held without strobe", sdo, s0);
      check(rx_full == 1'b0, "R5 no word without strobe", rx_full, 0);
    end
    run_frame(16'h0F0F, 16, 1'b1, 16'h4242, 16, 1'b0, 1'b0, "R6 delayed load");
    repeat (20) @(negedge clk);
    check(rx_q.size() == 0, "R5 all receive words seen", rx_q.size(), 0);

    // R2 per-pin direction
    cfg_write(8'h28);
    check({in_clk_oe, out_clk_oe, in_ld_oe, out_ld_oe} == 4'b1010, "R2 rx pins active",
          {in_clk_oe, out_clk_oe, in_ld_oe, out_ld_oe}, 4'b1010);
    cfg_write(8'h50);
    check({in_clk_oe, out_clk_oe, in_ld_oe, out_ld_oe} == 4'b0101, "R2 tx pins active",
          {in_clk_oe, out_clk_oe, in_ld_oe, out_ld_oe}, 4'b0101);

    // R9, R10 active clock and strobe over one whole frame
    repeat (400) @(negedge clk);
    begin
      int   rises = 0;
      int   highs = 0;
      logic prev  = out_clk_o;
      for (int c = 0; c < 2 * DUT_HD * DUT_FR; c++) begin
        @(negedge clk);
        if (out_clk_o && !prev) rises++;
        prev = out_clk_o;
        if (out_ld_o) highs++;
      end
      check(rises == DUT_FR, "R9 active clock rises per frame", rises, DUT_FR);
      check(highs == 2 * DUT_HD, "R10 active strobe high cycles", highs, 2 * DUT_HD);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule